// File: doc/BRIEF.md
# Memory Bus Quarter-State Sequencer

This block paces a memory interface. Each bus cycle is split into four quarter states, shown as codes 1 to 4 on the `quarter` output. Cycle requests enter a small internal queue, one per clock, each tagged with a kind: an address cycle, a read data cycle or a write data cycle. The sequencer takes requests from the queue in arrival order. It runs each one through the four quarters, reports the kind of the running cycle, and pulses a start strobe while the first quarter is on the outputs.

When the stretch enable is set, the block adds one extra copy of the fourth quarter after some cycles. This gives slow memories more row-address hold time and more time for the data bus to turn around. An extra quarter always follows an address cycle. One also follows a read data cycle whose successor in the queue is not another read. Streams of page-mode reads and all write cycles run without extra quarters. The rule is fixed and aimed at the worst-case access, so some of the added quarters are not strictly needed. The block keeps them anyway. When the queue runs dry, the sequencer parks in an idle state.

Top module: `bus_quarter_seq`

## Requirements
- R1: A cycle shows quarter codes 1, 2, 3, 4 on consecutive clocks. The code 0 means idle.
- R2: With stretch disabled, cycles waiting in the queue follow each other with no extra or idle states, and `stretch_flag` stays low.
- R3: A stretch is exactly one extra clock with quarter code 4 and `stretch_flag` high, directly after a normal quarter 4. `cyc_start` is high only while the quarter code is 1.
- R4: With stretch enabled, every address cycle (kind 0) is followed by a stretch.
- R5: With stretch enabled, a read cycle (kind 1) is followed by a stretch only if the next queued cycle is an address or a write. There is no stretch between two reads, and none after a read that has no successor waiting in the queue.
- R6: A write cycle (kind 2) is never followed by a stretch.
- R7: The stretch enable is sampled on the clock edge that enters quarter 1 of a cycle. A change later in that cycle has no effect on that cycle.
- R8: A request pushed into an empty, idle block shows quarter 1 on the outputs two clocks after the push clock. With an empty queue, the block returns to code 0 after quarter 4 or after the stretch.
- R9: The queue holds up to DEPTH requests and raises `req_full` when it is full. A push while `req_full` is high is dropped. Requests run in push order.
- R10: A synchronous active-high reset empties the queue and forces quarter 0, with `stretch_flag`, `cyc_start` and `req_full` low.
- R11: `cyc_kind` gives the kind of the running cycle (0 address, 1 read, 2 write) during all of its quarters, including its stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stretch_en | input | 1 | Enables extra quarter insertion; sampled when a cycle enters quarter 1 |
| req_push | input | 1 | Writes `req_kind` into the request queue |
| req_kind | input | 2 | Cycle kind: 0 address, 1 read, 2 write |
| req_full | output | 1 | The queue is full; pushes are dropped |
| quarter | output | 3 | Current quarter code: 0 idle, 1 to 4 |
| cyc_kind | output | 2 | Kind of the running cycle |
| cyc_start | output | 1 | High during quarter 1 |
| stretch_flag | output | 1 | High during the repeated quarter 4 |

## Verification
Seeded random bursts of mixed kinds, with the enable either on or off, are compared token by token with a quarter stream built from the rules. Two things are tested this way. The enable-off runs confirm that kind never changes the timing. The enable-on runs separate address stretches from read-turnaround stretches, and separate a read-to-read pair from a read followed by another kind. Directed bursts cover a page-mode run, a read followed by an address then a write, a trailing read with an empty queue, and writes only. One directed case toggles the enable in the middle of a cycle to show when it is sampled. An overfilled write burst, counted against `req_full`, shows which pushes are dropped.

// File: rtl/qsq_pkg.sv
package qsq_pkg;
  typedef enum logic [1:0] {
    CYC_ADDR  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_Q1   = 3'd1,
    ST_Q2   = 3'd2,
    ST_Q3   = 3'd3,
    ST_Q4   = 3'd4,
    ST_QS   = 3'd5
  } seq_state_t;

  localparam int KIND_W = 2;
  localparam int QCODE_W = 3;

  function automatic logic [QCODE_W-1:0] qcode(input seq_state_t s);
    case (s)
      ST_Q1:   qcode = 3'd1;
      ST_Q2:   qcode = 3'd2;
      ST_Q3:   qcode = 3'd3;
      ST_Q4:   qcode = 3'd4;
      ST_QS:   qcode = 3'd4;
      default: qcode = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/qsq_fifo.sv
module qsq_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == DEPTH_C);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/qsq_stretch_rule.sv
module qsq_stretch_rule
  import qsq_pkg::*;
(
  input  logic              en,
  input  logic [KIND_W-1:0] cur_kind,
  input  logic              next_valid,
  input  logic [KIND_W-1:0] next_kind,
  output logic              need
);
  logic addr_hold, read_turn;

  always_comb begin
    addr_hold = (cur_kind == CYC_ADDR);
    read_turn = (cur_kind == CYC_READ) && next_valid && (next_kind != CYC_READ);
    need      = en && (addr_hold || read_turn);
  end
endmodule

// File: rtl/qsq_fsm.sv
module qsq_fsm
  import qsq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              stretch_en,
  input  logic              q_empty,
  input  logic [KIND_W-1:0] q_head,
  output logic              q_pop,
  output seq_state_t        nxt_state,
  output logic [KIND_W-1:0] nxt_kind
);
  seq_state_t state_q;
  logic [KIND_W-1:0] cur_q;
  logic en_q;
  logic need;

  qsq_stretch_rule u_rule (
    .en        (en_q),
    .cur_kind  (cur_q),
    .next_valid(!q_empty),
    .next_kind (q_head),
    .need      (need)
  );

  always_comb begin
    q_pop     = 1'b0;
    nxt_state = state_q;
    case (state_q)
      ST_IDLE: if (!q_empty) begin
        q_pop = 1'b1;
        nxt_state = ST_Q1;
      end
      ST_Q1: nxt_state = ST_Q2;
      ST_Q2: nxt_state = ST_Q3;
      ST_Q3: nxt_state = ST_Q4;
      ST_Q4: begin
        if (need) nxt_state = ST_QS;
        else if (!q_empty) begin
          q_pop = 1'b1;
          nxt_state = ST_Q1;
        end else nxt_state = ST_IDLE;
      end
      ST_QS: begin
        if (!q_empty) begin
          q_pop = 1'b1;
          nxt_state = ST_Q1;
        end else nxt_state = ST_IDLE;
      end
      default: nxt_state = ST_IDLE;
    endcase
    if (q_pop) nxt_kind = q_head;
    else if (nxt_state == ST_IDLE) nxt_kind = '0;
    else nxt_kind = cur_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      en_q    <= 1'b0;
    end else begin
      state_q <= nxt_state;
      if (q_pop) begin
        cur_q <= q_head;
        en_q  <= stretch_en;
      end
    end
  end
endmodule

// File: rtl/qsq_outreg.sv
module qsq_outreg
  import qsq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  seq_state_t         nxt_state,
  input  logic [KIND_W-1:0]  nxt_kind,
  output logic [QCODE_W-1:0] quarter,
  output logic [KIND_W-1:0]  cyc_kind,
  output logic               cyc_start,
  output logic               stretch_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      quarter      <= '0;
      cyc_kind     <= '0;
      cyc_start    <= 1'b0;
      stretch_flag <= 1'b0;
    end else begin
      quarter      <= qcode(nxt_state);
      cyc_kind     <= nxt_kind;
      cyc_start    <= (nxt_state == ST_Q1);
      stretch_flag <= (nxt_state == ST_QS);
    end
  end
endmodule

// File: rtl/bus_quarter_seq.sv
module bus_quarter_seq
  import qsq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        stretch_en,
  input  logic        req_push,
  input  logic [1:0]  req_kind,
  output logic        req_full,
  output logic [2:0]  quarter,
  output logic [1:0]  cyc_kind,
  output logic        cyc_start,
  output logic        stretch_flag
);
  logic q_pop, q_empty;
  logic [KIND_W-1:0] q_head, nxt_kind;
  seq_state_t nxt_state;

  qsq_fifo #(.DEPTH(DEPTH), .WIDTH(KIND_W)) u_queue (
    .clk      (clk),
    .rst      (rst),
    .push     (req_push),
    .push_data(req_kind),
    .pop      (q_pop),
    .head     (q_head),
    .empty    (q_empty),
    .full     (req_full)
  );

  qsq_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .stretch_en(stretch_en),
    .q_empty   (q_empty),
    .q_head    (q_head),
    .q_pop     (q_pop),
    .nxt_state (nxt_state),
    .nxt_kind  (nxt_kind)
  );

  qsq_outreg u_out (
    .clk         (clk),
    .rst         (rst),
    .nxt_state   (nxt_state),
    .nxt_kind    (nxt_kind),
    .quarter     (quarter),
    .cyc_kind    (cyc_kind),
    .cyc_start   (cyc_start),
    .stretch_flag(stretch_flag)
  );
endmodule

// File: rtl/qsq_checker.sv
module qsq_checker (
  input logic       clk,
  input logic       rst,
  input logic       stretch_en,
  input logic [2:0] quarter,
  input logic [1:0] cyc_kind,
  input logic       cyc_start,
  input logic       stretch_flag
);
  // R1: quarters advance one per clock
  p_q1_to_q2_r1: assert property (@(posedge clk) disable iff (rst)
    quarter == 3'd1 |=> quarter == 3'd2);
  p_q2_to_q3_r1: assert property (@(posedge clk) disable iff (rst)
    quarter == 3'd2 |=> quarter == 3'd3);
  p_q3_to_q4_r1: assert property (@(posedge clk) disable iff (rst)
    quarter == 3'd3 |=> quarter == 3'd4);
  // R3: a stretch is a single repeat of a normal quarter 4
  p_stretch_after_q4_r3: assert property (@(posedge clk) disable iff (rst)
    stretch_flag |-> ($past(quarter) == 3'd4 && !$past(stretch_flag) && quarter == 3'd4));
  p_stretch_single_r3: assert property (@(posedge clk) disable iff (rst)
    stretch_flag |=> !stretch_flag);
  p_start_in_q1_r3: assert property (@(posedge clk) disable iff (rst)
    cyc_start |-> quarter == 3'd1);
  // R6: writes are never stretched
  p_write_unstretched_r6: assert property (@(posedge clk) disable iff (rst)
    stretch_flag |-> cyc_kind != 2'd2);
  // R7: enable sampled when quarter 1 is entered, five edges before the stretch shows
  p_enable_sampled_r7: assert property (@(posedge clk) disable iff (rst)
    stretch_flag |-> $past(stretch_en, 5));
  // R11: kind holds for the whole cycle
  p_kind_stable_r11: assert property (@(posedge clk) disable iff (rst)
    (quarter != 3'd0 && !cyc_start) |-> $stable(cyc_kind));
  // R10: reset leaves the block idle
  p_reset_idle_r10: assert property (@(posedge clk)
    $past(rst) |-> (quarter == 3'd0 && !stretch_flag && !cyc_start));
endmodule

bind bus_quarter_seq qsq_checker i_qsq_checker (
  .clk         (clk),
  .rst         (rst),
  .stretch_en  (stretch_en),
  .quarter     (quarter),
  .cyc_kind    (cyc_kind),
  .cyc_start   (cyc_start),
  .stretch_flag(stretch_flag)
);

// File: tb/test_bus_quarter_seq.sv
`timescale 1ns/1ps
module test_bus_quarter_seq;
  localparam int WIN = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stretch_en = 1'b0;
  logic req_push = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic req_full;
  logic [2:0] quarter;
  logic [1:0] cyc_kind;
  logic cyc_start, stretch_flag;

  int total = 0;
  int bad = 0;
  logic [1:0] burst [16];
  logic [6:0] rec [WIN];
  logic [6:0] expt [128];
  int exp_n;
  int accepted;
  bit full_seen;
  bit done = 0;

  always #4 clk = ~clk;

  bus_quarter_seq i_bus_quarter_seq (
    .clk(clk), .rst(rst), .stretch_en(stretch_en), .req_push(req_push),
    .req_kind(req_kind), .req_full(req_full), .quarter(quarter),
    .cyc_kind(cyc_kind), .cyc_start(cyc_start), .stretch_flag(stretch_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [6:0] tok(input logic [1:0] k, input bit s, input bit st, input int q);
    return {k, s, st, 3'(q)};
  endfunction

  function automatic bit wants_stretch(input int i, input int n, input bit en);
    if (!en) return 0;
    if (burst[i] == 2'd0) return 1;
    if (burst[i] == 2'd1 && i + 1 < n && burst[i+1] != 2'd1) return 1;
    return 0;
  endfunction

  function automatic void build_expect(input int n, input bit en);
    exp_n = 0;
    for (int i = 0; i < n; i++) begin
      expt[exp_n++] = tok(burst[i], 0, 1, 1);
      expt[exp_n++] = tok(burst[i], 0, 0, 2);
      expt[exp_n++] = tok(burst[i], 0, 0, 3);
      expt[exp_n++] = tok(burst[i], 0, 0, 4);
      if (wants_stretch(i, n, en)) expt[exp_n++] = tok(burst[i], 1, 0, 4);
    end
  endfunction

  function automatic string tag_for(input logic [6:0] e, input bit en);
    if (e[4] || en) begin
      case (e[6:5])
        2'd0: return "R4";
        2'd1: return "R5";
        default: return "R6";
      endcase
    end
    return "R2";
  endfunction

  task automatic run_burst(input int n, input bit en, input int flip_at);
    @(negedge clk);
    stretch_en = en;
    accepted = 0;
    full_seen = 0;
    fork
      begin
        for (int i = 0; i < n; i++) begin
          req_push = 1'b1;
          req_kind = burst[i];
          if (!req_full) accepted++;
          else full_seen = 1;
          @(negedge clk);
        end
        req_push = 1'b0;
      end
      begin
        for (int c = 0; c < WIN; c++) begin
          rec[c] = {cyc_kind, stretch_flag, cyc_start, quarter};
          if (c == flip_at) stretch_en = ~stretch_en;
          @(negedge clk);
        end
      end
    join
  endtask

  task automatic compare(input bit en);
    int first = -1;
    int extra = 0;
    for (int c = 0; c < WIN; c++)
      if (first < 0 && rec[c][2:0] != 3'd0) first = c;
    check(first == 2, "R8", first, 2);
    if (first < 0) return;
    for (int j = 0; j < exp_n; j++) begin
      if (first + j < WIN)
        check(rec[first+j] == expt[j], tag_for(expt[j], en), rec[first+j], expt[j]);
    end
    for (int c = first + exp_n; c < WIN; c++)
      if (rec[c][2:0] != 3'd0) extra++;
    check(extra == 0, "R8", extra, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check(quarter == 3'd0 && !stretch_flag && !cyc_start && !req_full, "R10",
          {quarter, stretch_flag, cyc_start, req_full}, 0);

    // R4 R5: page-mode read run: address then three reads
    burst[0] = 2'd0; burst[1] = 2'd1; burst[2] = 2'd1; burst[3] = 2'd1;
    run_burst(4, 1, -1); build_expect(4, 1); compare(1);

    // R5: address, read, address, write gives three stretches
    burst[0] = 2'd0; burst[1] = 2'd1; burst[2] = 2'd0; burst[3] = 2'd2;
    run_burst(4, 1, -1); build_expect(4, 1); compare(1);

    // R2: same pattern with stretch off
    run_burst(4, 0, -1); build_expect(4, 0); compare(0);

    // R5: read, read, write: stretch only before the write
    burst[0] = 2'd1; burst[1] = 2'd1; burst[2] = 2'd2;
    run_burst(3, 1, -1); build_expect(3, 1); compare(1);

    // R6: write only
    burst[0] = 2'd2; burst[1] = 2'd2;
    run_burst(2, 1, -1); build_expect(2, 1); compare(1);

    // R7: enable dropped during quarter 2 still stretches the address cycle
    burst[0] = 2'd0;
    run_burst(1, 1, 3); build_expect(1, 1); compare(1);
    // R7: enable raised during quarter 2 does not stretch
    run_burst(1, 0, 3); build_expect(1, 0); compare(0);

    // R9: overfill with writes
    for (int i = 0; i < 14; i++) burst[i] = 2'd2;
    run_burst(14, 0, -1);
    begin
      int starts = 0;
      for (int c = 0; c < WIN; c++) if (rec[c][3]) starts++;
      check(full_seen, "R9", full_seen, 1);
      check(starts == accepted, "R9", starts, accepted);
    end

    // R11 R4 R5 R6: random bursts
    for (int b = 0; b < 40; b++) begin
      int n = 1 + ($urandom % 8);
      bit en = 1'($urandom % 2);
      for (int i = 0; i < n; i++) burst[i] = 2'($urandom % 3);
      run_burst(n, en, -1); build_expect(n, en); compare(en);
    end

    // R10: reset while running clears everything
    burst[0] = 2'd0; burst[1] = 2'd1;
    @(negedge clk);
    stretch_en = 1; req_push = 1; req_kind = 2'd0;
    @(negedge clk); req_push = 0;
    repeat (3) @(negedge clk);
    rst = 1;
    @(negedge clk); rst = 0;
    check(quarter == 3'd0 && !stretch_flag && !cyc_start, "R10", quarter, 0);
    repeat (6) @(negedge clk);
    check(quarter == 3'd0, "R10", quarter, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule